// File: doc/BRIEF.md
# Soft-Start and Overcurrent Hiccup Sequencer

This block is the digital sequencer of a voltage-mode buck controller. A ramp code stands for the soft-start voltage. Once power-on reset is good and the controller is enabled, the ramp climbs by a fixed step on every switching-cycle tick and stops at full scale. A reference code is derived from the ramp. It stays at zero until the ramp passes an offset, then follows the ramp across a fixed window, and then holds at the regulation target. All voltages are integer codes in millivolts.

While the high-side switch is on, an overcurrent comparator flag ends the gate pulse at once through a kill strobe. After soft start has finished, the block counts consecutive switching cycles that see an overcurrent. When that count reaches the limit, the block enters hiccup. It discharges the ramp at a faster rate down to zero, releases it, and starts a fresh soft start.

Top module: `softstart_hiccup_seq`

## Requirements
- R1: While reset (rst_n low, sampled on the clock), por_ok low or enable low is seen at a clock edge, the block is disabled after that edge. In that state ramp_code is 0, ref_code is 0, ss_done is 0 and discharging is 0, and ticks do not move the ramp.
- R2: During soft start, each clock edge with tick high raises ramp_code by RAMP_STEP. The ramp saturates at RAMP_FULL (3300) and holds there.
- R3: ref_code is 0 while ramp_code is below 1000. Between 1000 and 1600 it equals ramp_code minus 1000. At 1600 and above it is 600.
- R4: kill goes high in the same cycle that hs_on and oc_flag are both high, whenever the block is not disabled, and this includes soft start. kill stays low while the block is disabled.
- R5: Overcurrent cycles seen during soft start never start a hiccup.
- R6: After soft start, a tick whose switching cycle saw an overcurrent counts as a fault cycle. The 8th consecutive fault cycle enters hiccup at that tick's edge: discharging rises, ss_done falls, and ramp_code is unchanged.
- R7: A tick whose cycle saw no overcurrent clears the consecutive-fault count. Seven faults, then a clean cycle, then seven more faults do not enter hiccup.
- R8: In hiccup, each tick lowers ramp_code by DIS_STEP, saturating at 0. The first tick that finds the ramp at 0 ends hiccup: discharging falls, and soft start resumes from 0.
- R9: ss_done rises at the edge where ramp_code reaches 3300. It clears on disable, on loss of por_ok, or on entry into hiccup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| por_ok | input | 1 | Supply power-on-reset good |
| enable | input | 1 | Controller enable request |
| tick | input | 1 | One-cycle strobe marking the end of a switching cycle |
| hs_on | input | 1 | High-side switch is on |
| oc_flag | input | 1 | Overcurrent comparator output |
| ramp_code | output | CODE_W | Soft-start ramp in millivolts |
| ref_code | output | CODE_W | Reference in millivolts |
| kill | output | 1 | Ends the current gate pulse |
| ss_done | output | 1 | Soft start complete |
| discharging | output | 1 | Hiccup discharge in progress |

## Verification
The bench builds the block with RAMP_STEP = 100 and DIS_STEP = 700. With these values, a full soft start takes only 33 ticks. The ramp lands exactly on 1000, 1300 and 1600, so the reference breakpoints can be checked at exact values. The discharge runs 3300, 2600, 1900, 1200, 500 and then has to saturate at 0 instead of stepping evenly down to it. The 8-cycle fault limit stays at its default, so the 7-then-clean-then-7 pattern and the exact 8th-tick entry into hiccup are both exercised.

// File: rtl/softstart_hiccup_seq.sv
module softstart_hiccup_seq #(
  parameter int CODE_W      = 12,
  parameter int RAMP_FULL   = 3300,
  parameter int EN_THRESH   = 1000,
  parameter int REF_SPAN    = 600,
  parameter int RAMP_STEP   = 10,
  parameter int DIS_STEP    = 100,
  parameter int FAULT_LIMIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_ok,
  input  logic              enable,
  input  logic              tick,
  input  logic              hs_on,
  input  logic              oc_flag,
  output logic [CODE_W-1:0] ramp_code,
  output logic [CODE_W-1:0] ref_code,
  output logic              kill,
  output logic              ss_done,
  output logic              discharging
);
  localparam int CNT_W = $clog2(FAULT_LIMIT + 1);
  localparam logic [CODE_W-1:0] FULL  = CODE_W'(RAMP_FULL);
  localparam logic [CODE_W-1:0] THR   = CODE_W'(EN_THRESH);
  localparam logic [CODE_W-1:0] TOP   = CODE_W'(EN_THRESH + REF_SPAN);
  localparam logic [CODE_W-1:0] SPAN  = CODE_W'(REF_SPAN);
  localparam logic [CODE_W:0]   STEP  = (CODE_W+1)'(RAMP_STEP);
  localparam logic [CODE_W-1:0] DSTEP = CODE_W'(DIS_STEP);
  localparam logic [CNT_W-1:0]  LAST  = CNT_W'(FAULT_LIMIT - 1);

  typedef enum logic [1:0] {S_OFF, S_SOFT, S_RUN, S_HIC} state_t;

  state_t            state;
  logic [CNT_W-1:0]  fault_cnt;
  logic              oc_seen;
  logic              active;
  logic              fault_cycle;
  logic [CODE_W:0]   ramp_up;

  assign active      = (state != S_OFF);
  assign kill        = active && hs_on && oc_flag;
  assign fault_cycle = oc_seen || kill;
  assign ramp_up     = {1'b0, ramp_code} + STEP;
  assign ss_done     = (state == S_RUN);
  assign discharging = (state == S_HIC);

  assign ref_code = (ramp_code < THR) ? '0 :
                    (ramp_code >= TOP) ? SPAN : (ramp_code - THR);

  always_ff @(posedge clk) begin
    if (!rst_n || !por_ok || !enable) begin
      state     <= S_OFF;
      ramp_code <= '0;
      fault_cnt <= '0;
      oc_seen   <= 1'b0;
    end else begin
      oc_seen <= tick ? 1'b0 : fault_cycle;
      case (state)
        S_OFF: begin
          state     <= S_SOFT;
          fault_cnt <= '0;
        end
        S_SOFT: begin
          fault_cnt <= '0;
          if (tick) begin
            if (ramp_up >= {1'b0, FULL}) begin
              ramp_code <= FULL;
              state     <= S_RUN;
            end else begin
              ramp_code <= ramp_up[CODE_W-1:0];
            end
          end
        end
        S_RUN: begin
          if (tick) begin
            if (!fault_cycle) begin
              fault_cnt <= '0;
            end else if (fault_cnt == LAST) begin
              fault_cnt <= '0;
              state     <= S_HIC;
            end else begin
              fault_cnt <= fault_cnt + 1'b1;
            end
          end
        end
        default: begin
          fault_cnt <= '0;
          if (tick) begin
            if (ramp_code == '0)        state     <= S_SOFT;
            else if (ramp_code <= DSTEP) ramp_code <= '0;
            else                        ramp_code <= ramp_code - DSTEP;
          end
        end
      endcase
    end
  end
endmodule

module softstart_hiccup_seq_chk #(
  parameter int CODE_W    = 12,
  parameter int RAMP_FULL = 3300,
  parameter int REF_SPAN  = 600
) (
  input logic              clk,
  input logic              rst_n,
  input logic              por_ok,
  input logic              enable,
  input logic              hs_on,
  input logic              oc_flag,
  input logic [CODE_W-1:0] ramp_code,
  input logic [CODE_W-1:0] ref_code,
  input logic              kill,
  input logic              ss_done,
  input logic              discharging
);
  assert_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!por_ok || !enable) |=> (ramp_code == '0 && !ss_done && !discharging));
  assert_ramp_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_code <= CODE_W'(RAMP_FULL));
  assert_ref_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ref_code <= CODE_W'(REF_SPAN));
  assert_kill_needs_oc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    kill |-> (hs_on && oc_flag));
  assert_hiccup_not_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ss_done && discharging));
  assert_discharge_falls_R8: assert property (@(posedge clk) disable iff (!rst_n)
    discharging |=> ramp_code <= $past(ramp_code));
  assert_done_at_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ss_done |-> ramp_code == CODE_W'(RAMP_FULL));
endmodule

bind softstart_hiccup_seq softstart_hiccup_seq_chk #(
  .CODE_W(CODE_W), .RAMP_FULL(RAMP_FULL), .REF_SPAN(REF_SPAN)
) i_chk (.*);

// File: tb/test_softstart_hiccup_seq.sv
module test_softstart_hiccup_seq;
  localparam int W = 12;
  logic clk = 1'b0, rst_n = 1'b0, por_ok = 1'b0, enable = 1'b0;
  logic tick = 1'b0, hs_on = 1'b0, oc_flag = 1'b0;
  logic [W-1:0] ramp_code, ref_code;
  logic kill, ss_done, discharging;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  softstart_hiccup_seq #(.CODE_W(W), .RAMP_STEP(100), .DIS_STEP(700)) i_softstart_hiccup_seq (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_tick(input bit oc, input string req);
    @(negedge clk);
    tick = 1'b1; hs_on = 1'b1; oc_flag = oc;
    #1 if (oc) chk(req, kill, 1);
    @(negedge clk);
    tick = 1'b0; hs_on = 1'b0; oc_flag = 1'b0;
  endtask

  task automatic ticks(input int n, input bit oc, input string req);
    for (int i = 0; i < n; i++) do_tick(oc, req);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 ramp", ramp_code, 0); chk("R1 ref", ref_code, 0);
    chk("R1 done", ss_done, 0); chk("R1 dis", discharging, 0);
    rst_n = 1'b1; por_ok = 1'b1;
    ticks(3, 0, "R1");
    chk("R1 ramp idle when not enabled", ramp_code, 0);
    @(negedge clk); hs_on = 1'b1; oc_flag = 1'b1;
    #1 chk("R4 kill low when disabled", kill, 0);
    hs_on = 1'b0; oc_flag = 1'b0;
  endtask

  task automatic t_softstart;
    enable = 1'b1; @(negedge clk);
    ticks(10, 0, "R2");
    chk("R2 ramp 1000", ramp_code, 1000); chk("R3 ref at 1000", ref_code, 0);
    ticks(3, 0, "R2");
    chk("R3 ref at 1300", ref_code, 300);
    ticks(3, 0, "R2");
    chk("R3 ref at 1600", ref_code, 600);
    ticks(10, 1, "R4 kill in soft start");
    chk("R2 ramp 2600", ramp_code, 2600);
    chk("R5 no hiccup in soft start", discharging, 0);
    ticks(6, 0, "R2");
    chk("R9 not done below full", ss_done, 0);
    ticks(1, 0, "R2");
    chk("R2 ramp full", ramp_code, 3300); chk("R9 done at full", ss_done, 1);
    ticks(2, 0, "R2");
    chk("R2 saturates", ramp_code, 3300); chk("R3 ref holds", ref_code, 600);
  endtask

  task automatic t_clear_count;
    ticks(7, 1, "R4");
    ticks(1, 0, "R7");
    ticks(7, 1, "R4");
    chk("R7 clean cycle clears count", discharging, 0);
    chk("R7 still done", ss_done, 1);
    ticks(1, 0, "R7");
  endtask

  task automatic t_hiccup;
    ticks(7, 1, "R4");
    chk("R6 no hiccup after 7", discharging, 0);
    ticks(1, 1, "R6");
    chk("R6 hiccup after 8", discharging, 1); chk("R6 done falls", ss_done, 0);
    chk("R6 ramp unchanged", ramp_code, 3300);
    ticks(1, 0, "R8"); chk("R8 step 1", ramp_code, 2600);
    ticks(3, 0, "R8"); chk("R8 step 4", ramp_code, 500);
    ticks(1, 0, "R8"); chk("R8 saturate 0", ramp_code, 0);
    chk("R8 still discharging", discharging, 1);
    ticks(1, 0, "R8"); chk("R8 released", discharging, 0);
    chk("R8 ramp at 0", ramp_code, 0);
    ticks(1, 0, "R8"); chk("R8 restart ramp", ramp_code, 100);
  endtask

  task automatic t_disable;
    ticks(32, 0, "R2");
    chk("R9 done again", ss_done, 1);
    @(negedge clk); enable = 1'b0; @(negedge clk);
    chk("R9 done clears on disable", ss_done, 0); chk("R1 ramp 0", ramp_code, 0);
    enable = 1'b1; @(negedge clk);
    ticks(12, 0, "R2");
    chk("R3 ref at 1200", ref_code, 200);
    @(negedge clk); por_ok = 1'b0; @(negedge clk);
    chk("R1 por loss ramp", ramp_code, 0); chk("R1 por loss ref", ref_code, 0);
    ticks(2, 0, "R1");
    chk("R1 ticks ignored", ramp_code, 0);
    por_ok = 1'b1; @(negedge clk);
  endtask

  initial begin
    t_reset(); t_softstart(); t_clear_count(); t_hiccup(); t_disable();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule